// File: doc/BRIEF.md
# Display Adapter Register Window Decoder

This block is the memory-mapped register window of a display adapter. It accepts one request at a time (address, access size, write data, direction) and routes it to one of four sub-windows: a relocated block of legacy byte-wide display ports, an indexed mode-register file, a small extension register bank, and a read-only display-identification table. Sub-windows that are disabled by parameter, and holes between them, read as zero and have no effect.

Legacy-port accesses leave on a byte-wide port bus, and a 16-bit access becomes two byte cycles, low byte first. Writing an index and its data with one 16-bit store is only possible because of this ordering. Mode-register accesses take the register index from the address and issue an index-load cycle followed by a 16-bit data cycle. The extension bank holds the framebuffer byte-order flag. The block also reports a device revision value that reflects whether the extension bank is built.

Top module: `disp_win_top`

## Requirements
- R1: A byte access at legacy-window offset k (window at 0x400, 32 bytes) makes exactly one port-bus cycle at port 0x3C0+k, and a read returns that port's byte in bits 7:0 with bits 31:8 zero.
- R2: A 16-bit write at legacy offset k makes two consecutive port-bus cycles: the first writes bits 7:0 to port 0x3C0+k, the second writes bits 15:8 to port 0x3C0+k+1.
- R3: A 16-bit read at legacy offset k returns port 0x3C0+k in bits 7:0 and port 0x3C0+k+1 in bits 15:8. A 32-bit access to the legacy window is handled as a 16-bit one, with bits 31:16 read as zero.
- R4: Each request gets exactly one single-cycle req_ready pulse. Counting clock edges from the first edge that sees req_valid, ready appears after 1 edge for extension, table and unmapped accesses, after 2 for a legacy byte, and after 3 for a split legacy access or any mode-register access.
- R5: An access at mode-window offset k (window at 0x500, 32 bytes) makes one index-load cycle carrying index k>>1, then one 16-bit data cycle. A read returns the data in bits 15:0.
- R6: A 32-bit read at extension offset 0 (window at 0x600, 8 bytes) returns the bank size, 8.
- R7: A 32-bit read at extension offset 4 returns 0x1E1E1E1E when the byte-order flag is clear (little-endian) and 0xBEBEBEBE when it is set. The flag is clear after reset, and be_flag shows it.
- R8: A 32-bit write at extension offset 4 sets the flag only for exactly 0xBEBEBEBE and clears it only for exactly 0x1E1E1E1E. Any other value leaves the flag unchanged.
- R9: Extension accesses that are not 32-bit, or that hit an offset other than 0 or 4, read zero and change nothing.
- R10: Offsets 0 to 383 form the identification table. A read drives id_addr with the offset and returns id_rdata in bits 7:0. Table writes have no effect, and offset 384 and above does not belong to the table.
- R11: Addresses outside every enabled sub-window read zero and cause no port-bus or mode-bus cycle.
- R12: revision reads 2 when the extension bank is built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit |
| req_addr | input | 12 | Byte offset within the 4 KB window |
| req_wdata | input | 32 | Write data, little-endian |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with req_ready |
| lp_valid | output | 1 | Legacy port-bus cycle |
| lp_write | output | 1 | Port-bus cycle is a write |
| lp_port | output | 16 | Port number |
| lp_wdata | output | 8 | Port write byte |
| lp_rdata | input | 8 | Port read byte, same cycle |
| mr_idx_we | output | 1 | Mode-register index load |
| mr_index | output | 4 | Mode-register index |
| mr_dat_en | output | 1 | Mode-register data cycle |
| mr_dat_write | output | 1 | Data cycle is a write |
| mr_wdata | output | 16 | Mode-register write data |
| mr_rdata | input | 16 | Mode-register read data, same cycle |
| id_addr | output | 9 | Identification table byte address |
| id_rdata | input | 8 | Identification table byte |
| be_flag | output | 1 | Framebuffer byte order, 1 = big-endian |
| revision | output | 8 | Device revision value |

## Verification
The assertions rely on the requester keeping a request steady until req_ready and lowering req_valid in the ready cycle. They also rely on the port bus and mode bus returning read data combinationally in the cycle of the strobe. Under those conditions the port and mode strobes never overlap, a second port cycle always targets the next port, and a mode data cycle always directly follows its index load. The bench stays within these limits. Its request task drives signals away from the clock edge and releases req_valid on the same sample that sees ready. Its bus models answer reads from their own storage, and the mode model latches the index on the load strobe, so the index-then-data order shows up in the data that comes back.

// File: rtl/disp_win_pkg.sv
package disp_win_pkg;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_IDTAB,
      RG_LEGACY,
      RG_MODE,
      RG_EXT
   } region_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LP_LO,
      ST_LP_HI,
      ST_MR_IDX,
      ST_MR_DAT,
      ST_DONE
   } seq_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam logic [31:0] ORDER_LITTLE = 32'h1E1E_1E1E;
   localparam logic [31:0] ORDER_BIG    = 32'hBEBE_BEBE;

endpackage

// File: rtl/disp_win_decode.sv
module disp_win_decode
   import disp_win_pkg::*;
#(
   parameter int              ADDR_W   = 12,
   parameter bit              ID_EN    = 1'b1,
   parameter bit              EXT_EN   = 1'b1,
   parameter int              ID_BYTES = 384,
   parameter int              LEG_OW   = 5,
   parameter int              MODE_OW  = 5,
   parameter int              EXT_OW   = 3,
   parameter logic [ADDR_W-1:0] LEG_BASE  = 'h400,
   parameter logic [ADDR_W-1:0] MODE_BASE = 'h500,
   parameter logic [ADDR_W-1:0] EXT_BASE  = 'h600
)(
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   logic id_hit, leg_hit, mode_hit, ext_hit;

   assign leg_hit  = (addr[ADDR_W-1:LEG_OW]  == LEG_BASE[ADDR_W-1:LEG_OW]);
   assign mode_hit = (addr[ADDR_W-1:MODE_OW] == MODE_BASE[ADDR_W-1:MODE_OW]);

   generate
      if (ID_EN) begin : g_id
         assign id_hit = (32'(addr) < 32'(ID_BYTES));
      end else begin : g_no_id
         assign id_hit = 1'b0;
      end

      if (EXT_EN) begin : g_ext
         assign ext_hit = (addr[ADDR_W-1:EXT_OW] == EXT_BASE[ADDR_W-1:EXT_OW]);
      end else begin : g_no_ext
         assign ext_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (id_hit)        region = RG_IDTAB;
      else if (leg_hit)  region = RG_LEGACY;
      else if (mode_hit) region = RG_MODE;
      else if (ext_hit)  region = RG_EXT;
      else               region = RG_NONE;
   end

endmodule

// File: rtl/disp_win_ext.sv
module disp_win_ext
   import disp_win_pkg::*;
#(
   parameter int EXT_OW    = 3,
   parameter int SIZE_OFF  = 0,
   parameter int ORDER_OFF = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [EXT_OW-1:0] off,
   input  logic [1:0]        size,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              be_flag
);

   localparam int          SPAN      = 1 << EXT_OW;
   localparam logic [31:0] SPAN_WORD = 32'(SPAN);

   logic word_acc, at_size, at_order, order_wr;

   assign word_acc = (size == SZ_WORD);
   assign at_size  = (32'(off) == 32'(SIZE_OFF));
   assign at_order = (32'(off) == 32'(ORDER_OFF));
   assign order_wr = wr_en && word_acc && at_order;

   always_comb begin
      rdata = '0;
      if (word_acc) begin
         if (at_size)       rdata = SPAN_WORD;
         else if (at_order) rdata = be_flag ? ORDER_BIG : ORDER_LITTLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_flag <= 1'b0;
      end else if (order_wr) begin
         if (wdata == ORDER_BIG)         be_flag <= 1'b1;
         else if (wdata == ORDER_LITTLE) be_flag <= 1'b0;
      end
   end

   // R8: the flag moves only after an exact code write to the order register
   a_r8_flag_only_on_code: assert property (@(posedge clk) disable iff (!rst_n)
      (be_flag != $past(be_flag)) |->
         $past(wr_en && word_acc && at_order &&
               (wdata == ORDER_BIG || wdata == ORDER_LITTLE)));

   // R8: the big-endian code sets the flag
   a_r8_big_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && word_acc && at_order && wdata == ORDER_BIG) |=> be_flag);

endmodule

// File: rtl/disp_win_top.sv
module disp_win_top
   import disp_win_pkg::*;
#(
   parameter int              ADDR_W        = 12,
   parameter bit              ID_EN         = 1'b1,
   parameter bit              EXT_EN        = 1'b1,
   parameter int              ID_BYTES      = 384,
   parameter int              LEG_OW        = 5,
   parameter int              MODE_OW       = 5,
   parameter int              EXT_OW        = 3,
   parameter logic [ADDR_W-1:0] LEG_BASE    = 'h400,
   parameter logic [ADDR_W-1:0] MODE_BASE   = 'h500,
   parameter logic [ADDR_W-1:0] EXT_BASE    = 'h600,
   parameter logic [15:0]     PORT_BASE     = 16'h03C0,
   parameter logic [7:0]      REV_PLAIN     = 8'd1,
   parameter logic [7:0]      REV_EXTENDED  = 8'd2,
   localparam int             ID_AW         = $clog2(ID_BYTES),
   localparam int             MIDX_W        = MODE_OW - 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic [31:0]       req_rdata,
   output logic              lp_valid,
   output logic              lp_write,
   output logic [15:0]       lp_port,
   output logic [7:0]        lp_wdata,
   input  logic [7:0]        lp_rdata,
   output logic              mr_idx_we,
   output logic [MIDX_W-1:0] mr_index,
   output logic              mr_dat_en,
   output logic              mr_dat_write,
   output logic [15:0]       mr_wdata,
   input  logic [15:0]       mr_rdata,
   output logic [ID_AW-1:0]  id_addr,
   input  logic [7:0]        id_rdata,
   output logic              be_flag,
   output logic [7:0]        revision
);

   // elaboration-time parameter checks
   generate
      if (LEG_BASE[LEG_OW-1:0] != '0)   begin : g_chk_leg  $error("legacy base not aligned");  end
      if (MODE_BASE[MODE_OW-1:0] != '0) begin : g_chk_mode $error("mode base not aligned");    end
      if (EXT_BASE[EXT_OW-1:0] != '0)   begin : g_chk_ext  $error("ext base not aligned");     end
      if (ID_EN && 32'(LEG_BASE) < ID_BYTES) begin : g_chk_id $error("table overlaps ports"); end
      if (MODE_OW < 2)                  begin : g_chk_mow  $error("mode window too small");    end
      if (EXT_OW < 3)                   begin : g_chk_eow  $error("ext window too small");     end
   endgenerate

   seq_state_e        st;
   region_e           region;
   logic              wr_q, split_q;
   logic [ADDR_W-1:0] off_q;
   logic [15:0]       wdata_q;
   logic [31:0]       rdata_q;
   logic [31:0]       ext_rdata;
   logic              accept, ext_wr, hi_phase;

   disp_win_decode #(
      .ADDR_W(ADDR_W), .ID_EN(ID_EN), .EXT_EN(EXT_EN), .ID_BYTES(ID_BYTES),
      .LEG_OW(LEG_OW), .MODE_OW(MODE_OW), .EXT_OW(EXT_OW),
      .LEG_BASE(LEG_BASE), .MODE_BASE(MODE_BASE), .EXT_BASE(EXT_BASE)
   ) u_decode (
      .addr   (req_addr),
      .region (region)
   );

   assign accept = (st == ST_IDLE) && req_valid;
   assign ext_wr = accept && req_write && (region == RG_EXT);

   disp_win_ext #(.EXT_OW(EXT_OW)) u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ext_wr),
      .off     (req_addr[EXT_OW-1:0]),
      .size    (req_size),
      .wdata   (req_wdata),
      .rdata   (ext_rdata),
      .be_flag (be_flag)
   );

   // request sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         wr_q    <= 1'b0;
         split_q <= 1'b0;
         off_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               wr_q    <= req_write;
               split_q <= (req_size != SZ_BYTE);
               off_q   <= req_addr;
               wdata_q <= req_wdata[15:0];
               rdata_q <= '0;
               unique case (region)
                  RG_LEGACY: st <= ST_LP_LO;
                  RG_MODE:   st <= ST_MR_IDX;
                  RG_EXT: begin
                     st <= ST_DONE;
                     if (!req_write) rdata_q <= ext_rdata;
                  end
                  RG_IDTAB: begin
                     st <= ST_DONE;
                     if (!req_write) rdata_q <= {24'b0, id_rdata};
                  end
                  default:   st <= ST_DONE;
               endcase
            end
            ST_LP_LO: begin
               if (!wr_q) rdata_q[7:0] <= lp_rdata;
               st <= split_q ? ST_LP_HI : ST_DONE;
            end
            ST_LP_HI: begin
               if (!wr_q) rdata_q[15:8] <= lp_rdata;
               st <= ST_DONE;
            end
            ST_MR_IDX: st <= ST_MR_DAT;
            ST_MR_DAT: begin
               if (!wr_q) rdata_q[15:0] <= mr_rdata;
               st <= ST_DONE;
            end
            ST_DONE:   st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   // legacy port bus
   assign hi_phase = (st == ST_LP_HI);
   assign lp_valid = (st == ST_LP_LO) || hi_phase;
   assign lp_write = lp_valid && wr_q;
   assign lp_port  = PORT_BASE + 16'(off_q[LEG_OW-1:0]) + 16'(hi_phase);
   assign lp_wdata = hi_phase ? wdata_q[15:8] : wdata_q[7:0];

   // mode-register bus
   assign mr_idx_we    = (st == ST_MR_IDX);
   assign mr_index     = off_q[MODE_OW-1:1];
   assign mr_dat_en    = (st == ST_MR_DAT);
   assign mr_dat_write = mr_dat_en && wr_q;
   assign mr_wdata     = wdata_q;

   // identification table and requester side
   assign id_addr   = req_addr[ID_AW-1:0];
   assign req_ready = (st == ST_DONE);
   assign req_rdata = rdata_q;

   generate
      if (EXT_EN) begin : g_rev_ext
         assign revision = REV_EXTENDED;
      end else begin : g_rev_plain
         assign revision = REV_PLAIN;
      end
   endgenerate

   // R2: a back-to-back port cycle always targets the following port
   a_r2_next_port: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_valid && $past(lp_valid)) |-> (lp_port == $past(lp_port) + 16'd1));

   // R4: ready is a single-cycle pulse
   a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R5: a mode data cycle directly follows its index load with the same index
   a_r5_index_first: assert property (@(posedge clk) disable iff (!rst_n)
      mr_dat_en |-> ($past(mr_idx_we) && mr_index == $past(mr_index)));

   // R11: the two downstream buses are never active together
   a_r11_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(lp_valid && (mr_idx_we || mr_dat_en)));

   // R4: no downstream strobe while ready is shown
   a_r4_quiet_at_ready: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(lp_valid || mr_idx_we || mr_dat_en));

endmodule

// File: tb/disp_win_top_tb.sv
module disp_win_top_tb;

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [11:0] addr;
      logic [31:0] wd;
      logic [31:0] exp;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd0, 12'h404, 32'h0,         32'h0000_00A4, 8'd1 },  // R1
      '{1'b1, 2'd1, 12'h400, 32'h0000_5511, 32'h0,         8'd2 },  // R2
      '{1'b0, 2'd1, 12'h400, 32'h0,         32'h0000_5511, 8'd3 },  // R3
      '{1'b0, 2'd1, 12'h40E, 32'h0,         32'h0000_AFAE, 8'd3 },  // R3
      '{1'b0, 2'd0, 12'h401, 32'h0,         32'h0000_0055, 8'd1 },  // R1
      '{1'b0, 2'd2, 12'h40E, 32'h0,         32'h0000_AFAE, 8'd3 },  // R3 word as half
      '{1'b1, 2'd1, 12'h506, 32'h0000_1234, 32'h0,         8'd5 },  // R5
      '{1'b0, 2'd1, 12'h506, 32'h0,         32'h0000_1234, 8'd5 },  // R5
      '{1'b0, 2'd1, 12'h500, 32'h0,         32'h0000_7000, 8'd5 },  // R5
      '{1'b0, 2'd1, 12'h51F, 32'h0,         32'h0000_700F, 8'd5 },  // R5
      '{1'b0, 2'd2, 12'h600, 32'h0,         32'h0000_0008, 8'd6 },  // R6
      '{1'b0, 2'd2, 12'h604, 32'h0,         32'h1E1E_1E1E, 8'd7 },  // R7
      '{1'b1, 2'd2, 12'h604, 32'hBEBE_BEBE, 32'h0,         8'd7 },  // R7
      '{1'b0, 2'd2, 12'h604, 32'h0,         32'hBEBE_BEBE, 8'd7 },  // R7
      '{1'b1, 2'd2, 12'h604, 32'h1234_5678, 32'h0,         8'd8 },  // R8
      '{1'b0, 2'd2, 12'h604, 32'h0,         32'hBEBE_BEBE, 8'd8 },  // R8
      '{1'b1, 2'd2, 12'h604, 32'h1E1E_1E1F, 32'h0,         8'd8 },  // R8 near-code
      '{1'b0, 2'd2, 12'h604, 32'h0,         32'hBEBE_BEBE, 8'd8 },  // R8
      '{1'b1, 2'd0, 12'h604, 32'h1E1E_1E1E, 32'h0,         8'd9 },  // R9 byte write
      '{1'b0, 2'd2, 12'h604, 32'h0,         32'hBEBE_BEBE, 8'd9 },  // R9
      '{1'b1, 2'd2, 12'h604, 32'h1E1E_1E1E, 32'h0,         8'd7 },  // R7
      '{1'b0, 2'd2, 12'h604, 32'h0,         32'h1E1E_1E1E, 8'd7 },  // R7
      '{1'b0, 2'd2, 12'h602, 32'h0,         32'h0,         8'd9 },  // R9
      '{1'b0, 2'd1, 12'h600, 32'h0,         32'h0,         8'd9 },  // R9
      '{1'b0, 2'd0, 12'h005, 32'h0,         32'h0000_0030, 8'd10},  // R10
      '{1'b0, 2'd0, 12'h17F, 32'h0,         32'h0000_00CA, 8'd10},  // R10
      '{1'b0, 2'd0, 12'h180, 32'h0,         32'h0,         8'd10},  // R10
      '{1'b0, 2'd2, 12'h700, 32'h0,         32'h0,         8'd11},  // R11
      '{1'b0, 2'd2, 12'hFFC, 32'h0,         32'h0,         8'd11}   // R11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] req_rdata;
   logic        lp_valid, lp_write;
   logic [15:0] lp_port;
   logic [7:0]  lp_wdata, lp_rdata;
   logic        mr_idx_we, mr_dat_en, mr_dat_write;
   logic [3:0]  mr_index;
   logic [15:0] mr_wdata, mr_rdata;
   logic [8:0]  id_addr;
   logic [7:0]  id_rdata;
   logic        be_flag;
   logic [7:0]  revision;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;  // 200 MHz

   disp_win_top u_dut (.*);

   // legacy port model with access log
   logic [7:0]  port_mem [32];
   logic [15:0] log_port [64];
   logic [7:0]  log_data [64];
   int          lp_cnt = 0;
   int          mr_cnt = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) port_mem[i] <= 8'hA0 + 8'(i);
      end else if (lp_valid) begin
         log_port[lp_cnt[5:0]] <= lp_port;
         log_data[lp_cnt[5:0]] <= lp_write ? lp_wdata : lp_rdata;
         lp_cnt <= lp_cnt + 1;
         if (lp_write) port_mem[lp_port[4:0]] <= lp_wdata;
      end
   end
   assign lp_rdata = port_mem[lp_port[4:0]];

   // mode register model: index latched on load strobe
   logic [15:0] mregs [16];
   logic [3:0]  midx;
   always @(posedge clk) begin
      if (!rst_n) begin
         midx <= '0;
         for (int i = 0; i < 16; i++) mregs[i] <= 16'h7000 + 16'(i);
      end else begin
         if (mr_idx_we) midx <= mr_index;
         if (mr_dat_en && mr_dat_write) mregs[midx] <= mr_wdata;
         if (mr_idx_we || mr_dat_en) mr_cnt <= mr_cnt + 1;
      end
   end
   assign mr_rdata = mregs[midx];

   // identification table model
   assign id_rdata = id_addr[7:0] ^ {id_addr[8], 7'h35};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_req(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                         input logic [31:0] wd, output logic [31:0] rd, output int cyc);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!req_ready && cyc < 50);
      rd = req_rdata;
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int          cyc;
      int          base_lp, base_mr;
      repeat (3) @(negedge clk);
      // reset state
      chk("R4 reset ready", 32'(req_ready), 32'd0);
      chk("R7 reset be_flag", 32'(be_flag), 32'd0);
      chk("R11 reset strobes", 32'({lp_valid, mr_idx_we, mr_dat_en}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 revision", 32'(revision), 32'd2);

      // vector table
      for (int i = 0; i < NV; i++) begin
         do_req(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd, rd, cyc);
         if (!VECS[i].wr)
            chk($sformatf("R%0d vec%0d rdata", VECS[i].rq, i), rd, VECS[i].exp);
      end
      chk("R7 be_flag after table", 32'(be_flag), 32'd0);

      // R2: ordering of a split write
      base_lp = lp_cnt;
      do_req(1'b1, 2'd1, 12'h408, 32'h0000_C3B2, rd, cyc);
      chk("R4 split write latency", 32'(cyc), 32'd3);
      chk("R2 two port cycles", 32'(lp_cnt - base_lp), 32'd2);
      chk("R2 first port", 32'(log_port[base_lp[5:0]]), 32'h3C8);
      chk("R2 first byte", 32'(log_data[base_lp[5:0]]), 32'hB2);
      chk("R2 second port", 32'(log_port[6'(base_lp + 1)]), 32'h3C9);
      chk("R2 second byte", 32'(log_data[6'(base_lp + 1)]), 32'hC3);

      // R1: byte access is one cycle on the expected port
      base_lp = lp_cnt;
      do_req(1'b0, 2'd0, 12'h41F, 32'h0, rd, cyc);
      chk("R1 byte rdata", rd, 32'h0000_00BF);
      chk("R1 single cycle", 32'(lp_cnt - base_lp), 32'd1);
      chk("R1 port number", 32'(log_port[base_lp[5:0]]), 32'h3DF);
      chk("R4 byte latency", 32'(cyc), 32'd2);
      @(negedge clk);
      chk("R4 ready dropped", 32'(req_ready), 32'd0);

      // R5: mode access latency and bus cycles
      base_mr = mr_cnt;
      do_req(1'b0, 2'd2, 12'h506, 32'h0, rd, cyc);
      chk("R5 mode rdata", rd, 32'h0000_1234);
      chk("R5 two mode cycles", 32'(mr_cnt - base_mr), 32'd2);
      chk("R4 mode latency", 32'(cyc), 32'd3);

      // R11: unmapped write touches nothing
      base_lp = lp_cnt;
      base_mr = mr_cnt;
      do_req(1'b1, 2'd2, 12'h700, 32'hBEBE_BEBE, rd, cyc);
      chk("R4 unmapped latency", 32'(cyc), 32'd1);
      chk("R11 no port cycle", 32'(lp_cnt - base_lp), 32'd0);
      chk("R11 no mode cycle", 32'(mr_cnt - base_mr), 32'd0);
      chk("R11 flag untouched", 32'(be_flag), 32'd0);

      // R10: table write ignored, table unchanged
      do_req(1'b1, 2'd0, 12'h005, 32'hFF, rd, cyc);
      do_req(1'b0, 2'd0, 12'h005, 32'h0, rd, cyc);
      chk("R10 table after write", rd, 32'h0000_0030);
      chk("R4 table latency", 32'(cyc), 32'd1);

      // R8: big-endian code sets the flag port
      do_req(1'b1, 2'd2, 12'h604, 32'hBEBE_BEBE, rd, cyc);
      chk("R8 be_flag set", 32'(be_flag), 32'd1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule